// File: doc/BRIEF.md
# Framed Link Error Counter Bank

The block holds six saturating error counters for the receive side of a framed E1/T1 link. Its inputs are single-cycle pulses from the event detectors: CRC errors, line code violations, severely errored frames, loss of frame alignment, change of frame alignment and multiframe sync loss. A host reads the six count outputs as plain registers. A clear input zeroes every counter and holds it at zero for as long as it stays high.

In sample mode each counter keeps counting in a hidden accumulator. The outputs change only on a one-second tick, when they take the accumulated totals and the accumulators start again. Outside sample mode the outputs show the accumulators directly. An optional out-of-frame pause stops only the line code violation counter while the link has lost frame synchronization.

The event detectors and the one-second timer are outside this block. Both the event pulses and the tick are plain control inputs with no handshake. The block has no back-pressure: it never refuses an event.

Top module: `flec_bank`

## Requirements
- R1: After reset all six count outputs read zero.
- R2: With sample mode off, a pulse on an event input raises that channel's count output by exactly one. The new value shows on the output after the clock edge that samples the pulse. Channels are independent, and any combination of pulses may arrive in the same cycle.
- R3: Counters saturate at all-ones and never wrap. The line code violation and CRC channels are WIDE_W bits wide (16 by default). The other four channels are NARROW_W bits wide (8 by default).
- R4: While `clr_i` is high, every count output reads zero from the next edge onwards, and so does every internal accumulator. Counting resumes from zero once `clr_i` falls.
- R5: Clear takes priority over event pulses and over the one-second tick.
- R6: With sample mode on, the count outputs hold their values on every cycle without a tick.
- R7: In sample mode, a tick copies each accumulated total to the output. The accumulator restarts at zero, or at one if that channel's event pulses in the tick cycle. That event does not appear in the copied value.
- R8: With the pause option on and `frame_lost_i` high, line code violation pulses are not counted.
- R9: With the pause option off, line code violation pulses are counted whatever the state of `frame_lost_i`.
- R10: The pause option and `frame_lost_i` have no effect on the other five channels.
- R11: Leaving sample mode shows the live accumulators at once. This includes events counted since the last tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear all counters and hold them at zero while high |
| snap_mode_i | input | 1 | Sample mode: outputs update only on `sec_tick_i` |
| sec_tick_i | input | 1 | One-second tick pulse |
| pause_oof_i | input | 1 | Pause the line code violation count while frame is lost |
| frame_lost_i | input | 1 | Frame synchronization is lost |
| ev_cofa_i | input | 1 | Change of frame alignment pulse |
| ev_lofa_i | input | 1 | Loss of frame alignment pulse |
| ev_lcv_i | input | 1 | Line code violation pulse |
| ev_crc_i | input | 1 | CRC error pulse |
| ev_sef_i | input | 1 | Severely errored frame pulse |
| ev_mfoos_i | input | 1 | Multiframe out of sync pulse |
| cofa_cnt_o | output | NARROW_W | Change of frame alignment count |
| lofa_cnt_o | output | NARROW_W | Loss of frame alignment count |
| lcv_cnt_o | output | WIDE_W | Line code violation count |
| crc_cnt_o | output | WIDE_W | CRC error count |
| sef_cnt_o | output | NARROW_W | Severely errored frame count |
| mfoos_cnt_o | output | NARROW_W | Multiframe out of sync count |

## Verification
Each result shows up one edge after its stimulus: an event, a clear or a tick sampled at one rising edge is visible on the outputs right after that edge. A change of sample mode alters the outputs at once, because only an output multiplexer sits on that path. The bench drives inputs on the falling edge. It updates its arithmetic model at the next rising edge and compares all six outputs at the following falling edge, so each stimulus is checked exactly one edge later. The sweeps cover every combination of event pulses under each pause and frame-loss setting, and they count all channels up to their saturation limits.

// File: rtl/flec_pkg.sv
package flec_pkg;
  localparam int unsigned NUM_CH = 6;

  typedef enum int unsigned {
    CH_COFA  = 0,
    CH_LOFA  = 1,
    CH_LCV   = 2,
    CH_CRC   = 3,
    CH_SEF   = 4,
    CH_MFOOS = 5
  } flec_ch_e;

  function automatic bit ch_is_wide(int unsigned ch);
    return (ch == CH_LCV) || (ch == CH_CRC);
  endfunction
endpackage

// File: rtl/flec_event_gate.sv
module flec_event_gate #(
  parameter int unsigned N        = 6,
  parameter int unsigned PAUSE_CH = 2
) (
  input  logic [N-1:0] ev_i,
  input  logic         pause_en_i,
  input  logic         frame_lost_i,
  output logic [N-1:0] hit_o
);
  logic hold;
  assign hold = pause_en_i & frame_lost_i;

  for (genvar g = 0; g < N; g++) begin : g_gate
    if (g == PAUSE_CH) begin : g_pausable
      assign hit_o[g] = ev_i[g] & ~hold;
    end else begin : g_plain
      assign hit_o[g] = ev_i[g];
    end
  end
endmodule

// File: rtl/flec_sat_counter.sv
module flec_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         hit_i,
  input  logic         snap_mode_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] acc_q;
  logic [W-1:0] vis_q;
  logic         take;

  assign take = snap_mode_i & tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vis_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      vis_q <= '0;
    end else if (take) begin
      vis_q <= acc_q;
      acc_q <= hit_i ? ONE : '0;
    end else if (hit_i && (acc_q != MAXV)) begin
      acc_q <= acc_q + ONE;
    end
  end

  assign count_o = snap_mode_i ? vis_q : acc_q;
endmodule

// File: rtl/flec_bank.sv
module flec_bank #(
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned WIDE_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                snap_mode_i,
  input  logic                sec_tick_i,
  input  logic                pause_oof_i,
  input  logic                frame_lost_i,
  input  logic                ev_cofa_i,
  input  logic                ev_lofa_i,
  input  logic                ev_lcv_i,
  input  logic                ev_crc_i,
  input  logic                ev_sef_i,
  input  logic                ev_mfoos_i,
  output logic [NARROW_W-1:0] cofa_cnt_o,
  output logic [NARROW_W-1:0] lofa_cnt_o,
  output logic [WIDE_W-1:0]   lcv_cnt_o,
  output logic [WIDE_W-1:0]   crc_cnt_o,
  output logic [NARROW_W-1:0] sef_cnt_o,
  output logic [NARROW_W-1:0] mfoos_cnt_o
);
  import flec_pkg::*;

  logic [NUM_CH-1:0] ev_vec;
  logic [NUM_CH-1:0] hit_vec;

  assign ev_vec[CH_COFA]  = ev_cofa_i;
  assign ev_vec[CH_LOFA]  = ev_lofa_i;
  assign ev_vec[CH_LCV]   = ev_lcv_i;
  assign ev_vec[CH_CRC]   = ev_crc_i;
  assign ev_vec[CH_SEF]   = ev_sef_i;
  assign ev_vec[CH_MFOOS] = ev_mfoos_i;

  flec_event_gate #(
    .N        (NUM_CH),
    .PAUSE_CH (CH_LCV)
  ) u_gate (
    .ev_i         (ev_vec),
    .pause_en_i   (pause_oof_i),
    .frame_lost_i (frame_lost_i),
    .hit_o        (hit_vec)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int unsigned W = ch_is_wide(g) ? WIDE_W : NARROW_W;
    logic [W-1:0] cnt;

    flec_sat_counter #(.W(W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr_i),
      .hit_i       (hit_vec[g]),
      .snap_mode_i (snap_mode_i),
      .tick_i      (sec_tick_i),
      .count_o     (cnt)
    );

    if (g == CH_COFA) begin : g_o
      assign cofa_cnt_o = cnt;
    end else if (g == CH_LOFA) begin : g_o
      assign lofa_cnt_o = cnt;
    end else if (g == CH_LCV) begin : g_o
      assign lcv_cnt_o = cnt;
    end else if (g == CH_CRC) begin : g_o
      assign crc_cnt_o = cnt;
    end else if (g == CH_SEF) begin : g_o
      assign sef_cnt_o = cnt;
    end else begin : g_o
      assign mfoos_cnt_o = cnt;
    end
  end
endmodule

// File: rtl/flec_bank_chk.sv
module flec_bank_chk #(
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned WIDE_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr_i,
  input logic                snap_mode_i,
  input logic                sec_tick_i,
  input logic                pause_oof_i,
  input logic                frame_lost_i,
  input logic                ev_cofa_i,
  input logic                ev_lofa_i,
  input logic                ev_lcv_i,
  input logic                ev_crc_i,
  input logic                ev_sef_i,
  input logic                ev_mfoos_i,
  input logic [NARROW_W-1:0] cofa_cnt_o,
  input logic [NARROW_W-1:0] lofa_cnt_o,
  input logic [WIDE_W-1:0]   lcv_cnt_o,
  input logic [WIDE_W-1:0]   crc_cnt_o,
  input logic [NARROW_W-1:0] sef_cnt_o,
  input logic [NARROW_W-1:0] mfoos_cnt_o
);
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cofa_cnt_o == '0 && lofa_cnt_o == '0 && lcv_cnt_o == '0 &&
               crc_cnt_o == '0 && sef_cnt_o == '0 && mfoos_cnt_o == '0));

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !snap_mode_i) |=> (snap_mode_i ||
      (lcv_cnt_o >= $past(lcv_cnt_o) && cofa_cnt_o >= $past(cofa_cnt_o))));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !snap_mode_i && !ev_crc_i) |=> (snap_mode_i || $stable(crc_cnt_o)));

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_mode_i && !sec_tick_i && !clr_i) |=> (!snap_mode_i ||
      ($stable(cofa_cnt_o) && $stable(lcv_cnt_o) && $stable(mfoos_cnt_o))));

  // R8
  oof_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_oof_i && frame_lost_i && !clr_i && !snap_mode_i) |=>
      (snap_mode_i || $stable(lcv_cnt_o)));

  // R10
  other_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sef_i && !clr_i && !snap_mode_i && sef_cnt_o != '1) |=>
      (snap_mode_i || sef_cnt_o != $past(sef_cnt_o)));

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (cofa_cnt_o == '0 && lcv_cnt_o == '0);
    end
  end
endmodule

bind flec_bank flec_bank_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (.*);

// File: tb/tb_flec_bank.sv
`timescale 1ns/1ps
module tb_flec_bank;
  localparam int NW = 8;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, snap = 0, tick = 0, pause = 0, lost = 0;
  logic [5:0] ev = '0;
  logic [NW-1:0] cofa, lofa, sef, mfoos;
  logic [WW-1:0] lcv, crc;

  always #2.5 clk = ~clk;

  flec_bank #(.NARROW_W(NW), .WIDE_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .snap_mode_i(snap),
    .sec_tick_i(tick), .pause_oof_i(pause), .frame_lost_i(lost),
    .ev_cofa_i(ev[0]), .ev_lofa_i(ev[1]), .ev_lcv_i(ev[2]),
    .ev_crc_i(ev[3]), .ev_sef_i(ev[4]), .ev_mfoos_i(ev[5]),
    .cofa_cnt_o(cofa), .lofa_cnt_o(lofa), .lcv_cnt_o(lcv),
    .crc_cnt_o(crc), .sef_cnt_o(sef), .mfoos_cnt_o(mfoos));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int acc [6];
  int vis [6];

  function automatic int lim(int i);
    return (i == 2 || i == 3) ? (1 << WW) - 1 : (1 << NW) - 1;
  endfunction

  function automatic int got(int i);
    case (i)
      0: return int'(cofa);
      1: return int'(lofa);
      2: return int'(lcv);
      3: return int'(crc);
      4: return int'(sef);
      default: return int'(mfoos);
    endcase
  endfunction

  task automatic compare(string req);
    for (int i = 0; i < 6; i++) begin
      int exp = snap ? vis[i] : acc[i];
      checks++;
      if (got(i) != exp) begin
        errors++;
        $display("FAIL %s channel %0d actual %0d expected %0d", req, i, got(i), exp);
      end
    end
  endtask

  task automatic cyc(input logic [5:0] e, input logic t, input string req);
    ev = e; tick = t;
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      bit h = e[i] && !(i == 2 && pause && lost);
      if (clr) begin acc[i] = 0; vis[i] = 0; end
      else if (snap && t) begin vis[i] = acc[i]; acc[i] = h ? 1 : 0; end
      else if (h && acc[i] < lim(i)) acc[i]++;
    end
    @(negedge clk);
    ev = '0; tick = 0;
    compare(req);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin acc[i] = 0; vis[i] = 0; end
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: every event combination in live mode
    for (int v = 0; v < 64; v++) cyc(6'(v), 1'b0, "R2");

    // R8 R9 R10: pause and frame loss combinations
    for (int m = 0; m < 4; m++) begin
      pause = m[0]; lost = m[1];
      for (int v = 0; v < 64; v++)
        cyc(6'(v), 1'b0, (m == 3) ? "R8" : (m[0] ? "R10" : "R9"));
    end
    pause = 0; lost = 0;

    // R4 R5: clear overrides events and tick
    clr = 1;
    cyc(6'h3f, 1'b0, "R4");
    snap = 1;
    cyc(6'h3f, 1'b1, "R5");
    snap = 0;
    cyc(6'h15, 1'b0, "R5");
    clr = 0;
    cyc(6'h3f, 1'b0, "R4");
    cyc(6'h2a, 1'b0, "R4");

    // R6 R7: sample mode with ticks, some on event cycles
    snap = 1;
    for (int k = 0; k < 120; k++) begin
      logic t = (k % 10) == 9;
      cyc(6'((k * 37 + 5) & 63), t, t ? "R7" : "R6");
    end
    lost = 1; pause = 1;
    for (int k = 0; k < 30; k++) cyc(6'h3f, (k % 7) == 6, "R8");
    lost = 0; pause = 0;
    // R11: leaving sample mode shows live accumulators
    snap = 0;
    @(negedge clk);
    compare("R11");

    // R3: saturation of both widths
    clr = 1; cyc(6'h00, 1'b0, "R4"); clr = 0;
    for (int k = 0; k < (1 << WW) + 4; k++) cyc(6'h3f, 1'b0, "R3");
    cyc(6'h3f, 1'b0, "R3");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule